// File: doc/BRIEF.md
# Total-Order Floating-Point Compare Unit

This unit compares two IEEE-754 binary operands, either both single precision or both double precision. It returns a two-bit code that answers one question: is the first operand strictly below the second? The compare raises no exceptions and has no flag outputs. Signaling and quiet NaNs give the same result, and the unit never reports an invalid-operation condition.

Two cases depart from an ordinary quiet compare. First, the code does not separate "equal" from "greater". Second, negative zero sorts below positive zero. When the result is unordered, the code also shows which operand caused it: a NaN in the second operand takes precedence over a NaN in the first.

A caller puts both operands on the data inputs, selects the precision and pulses the start input for one cycle. The registered code and a one-cycle done pulse appear on the next clock edge. A new start may be issued in every cycle.

Top module: `lexcmp_unit`

## Requirements
- R1: While reset is asserted (`rst_n` low), `done_o` is 0 and `code_o` is 2'b00.
- R2: `done_o` is 1 in the cycle after each cycle in which `start_i` is 1, and 0 in every other cycle. `code_o` takes the new result on that same clock edge.
- R3: When `start_i` is 0, `code_o` keeps its previous value, even if the operands or the precision select change.
- R4: For ordered, unequal operands, the code is 2'b01 when the first operand is less than the second and 2'b00 when it is greater. This holds for negative operands compared with each other and for operands of mixed sign.
- R5: For equal nonzero operands, the code is 2'b00.
- R6: A first operand of -0 with a second operand of +0 gives 2'b01. A first operand of +0 with a second of -0 gives 2'b00. Two zeros of the same sign give 2'b00.
- R7: If the second operand is a NaN, the code is 2'b11, whatever the first operand holds. A NaN is any value whose exponent field is all ones and whose fraction is nonzero; quiet and signaling NaNs count alike.
- R8: If the first operand is a NaN and the second is not, the code is 2'b10.
- R9: Infinities are ordered values, not NaNs. +inf is above every finite value and -inf is below every finite value.
- R10: With `dbl_i` = 0, each operand is a single-precision value in bits [31:0] and bits [63:32] are ignored. With `dbl_i` = 1, all 64 bits form a double-precision value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe; one compare per cycle in which it is high |
| dbl_i | input | 1 | Precision select: 0 single, 1 double |
| op_a_i | input | 64 | First operand |
| op_b_i | input | 64 | Second operand |
| code_o | output | 2 | Result code: 00 not less, 01 less, 10 first operand NaN, 11 second operand NaN |
| done_o | output | 1 | One-cycle pulse marking a new code |

## Verification
Two functions can fall in the same cycle here. One pair is the capture of a new result and the output of the previous one: the bench holds start high on consecutive cycles with different operand pairs and requires `done_o` to stay high while each code follows its own pair, one cycle later. The other pair is the NaN rules, which can both apply to one compare. When both operands are NaNs, the bench expects the second-operand code 2'b11. When both operands are zeros of opposite sign, the bench checks that the zero-sign rule, not plain equality, decides the code.

// File: rtl/lexcmp_pkg.sv
`timescale 1ns/1ps
package lexcmp_pkg;
    localparam int DW        = 64;
    localparam int SP_W      = 32;
    localparam int SP_EXP_W  = 8;
    localparam int SP_FRAC_W = 23;
    localparam int DP_EXP_W  = 11;
    localparam int DP_FRAC_W = 52;
    localparam int MAG_W     = DW - 1;

    typedef enum logic [1:0] {
        CODE_NOT_LESS = 2'd0,
        CODE_LESS     = 2'd1,
        CODE_UNORD_A  = 2'd2,
        CODE_UNORD_B  = 2'd3
    } code_e;

    typedef struct packed {
        logic             sign;
        logic             nan;
        logic             zero;
        logic [MAG_W-1:0] mag;
    } opnd_t;

    typedef struct packed {
        logic  done;
        code_e code;
    } state_t;
endpackage

// File: rtl/lexcmp_classify.sv
`timescale 1ns/1ps
module lexcmp_classify
    import lexcmp_pkg::*;
(
    input  logic [DW-1:0] raw_i,
    input  logic          dbl_i,
    output opnd_t         info_o
);
    logic             exp_ones;
    logic             frac_nz;
    logic             sign;
    logic [MAG_W-1:0] mag;

    always_comb begin
        if (dbl_i) begin
            sign     = raw_i[DW-1];
            exp_ones = &raw_i[DW-2 -: DP_EXP_W];
            frac_nz  = |raw_i[DP_FRAC_W-1:0];
            mag      = raw_i[MAG_W-1:0];
        end else begin
            sign     = raw_i[SP_W-1];
            exp_ones = &raw_i[SP_W-2 -: SP_EXP_W];
            frac_nz  = |raw_i[SP_FRAC_W-1:0];
            mag      = MAG_W'(raw_i[SP_W-2:0]);
        end
        info_o.sign = sign;
        info_o.mag  = mag;
        info_o.nan  = exp_ones & frac_nz;
        info_o.zero = (mag == '0);
    end
endmodule

// File: rtl/lexcmp_order.sv
`timescale 1ns/1ps
module lexcmp_order
    import lexcmp_pkg::*;
(
    input  opnd_t a_i,
    input  opnd_t b_i,
    output code_e code_o
);
    logic mag_lt;
    logic mag_gt;
    logic lt;

    always_comb begin
        mag_lt = (a_i.mag < b_i.mag);
        mag_gt = (a_i.mag > b_i.mag);
        if (a_i.zero && b_i.zero)
            lt = a_i.sign && !b_i.sign;      // -0 below +0
        else if (a_i.sign != b_i.sign)
            lt = a_i.sign;
        else if (!a_i.sign)
            lt = mag_lt;
        else
            lt = mag_gt;                     // both negative: order reversed

        if (b_i.nan)
            code_o = CODE_UNORD_B;
        else if (a_i.nan)
            code_o = CODE_UNORD_A;
        else if (lt)
            code_o = CODE_LESS;
        else
            code_o = CODE_NOT_LESS;
    end
endmodule

// File: rtl/lexcmp_unit.sv
`timescale 1ns/1ps
module lexcmp_unit
    import lexcmp_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          dbl_i,
    input  logic [DW-1:0] op_a_i,
    input  logic [DW-1:0] op_b_i,
    output logic [1:0]    code_o,
    output logic          done_o
);
    localparam int N_OPND = 2;

    logic [DW-1:0] raw [N_OPND];
    opnd_t         info [N_OPND];
    code_e         cmp_code;
    state_t        st_d;
    state_t        st_q;

    assign raw[0] = op_a_i;
    assign raw[1] = op_b_i;

    for (genvar g = 0; g < N_OPND; g++) begin : g_cls
        lexcmp_classify cls_i (
            .raw_i  (raw[g]),
            .dbl_i  (dbl_i),
            .info_o (info[g])
        );
    end

    lexcmp_order ord_i (
        .a_i    (info[0]),
        .b_i    (info[1]),
        .code_o (cmp_code)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = start_i;
        if (start_i)
            st_d.code = cmp_code;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '{done: 1'b0, code: CODE_NOT_LESS};
        else
            st_q <= st_d;
    end

    assign code_o = st_q.code;
    assign done_o = st_q.done;

    // R2
    done_follows_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> done_o);
    // R2
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> !done_o);
    // R3
    code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> $stable(code_o));
    // R7
    b_nan_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && info[1].nan) |=> (code_o == 2'b11));
    // R8
    a_nan_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && info[0].nan && !info[1].nan) |=> (code_o == 2'b10));
endmodule

// File: tb/lexcmp_unit_tb.sv
`timescale 1ns/1ps
module lexcmp_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        dbl_i = 1'b0;
    logic [63:0] op_a_i = '0;
    logic [63:0] op_b_i = '0;
    logic [1:0]  code_o;
    logic        done_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    lexcmp_unit dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .dbl_i(dbl_i),
        .op_a_i(op_a_i), .op_b_i(op_b_i), .code_o(code_o), .done_o(done_o)
    );

    localparam logic [31:0] S_ONE = 32'h3F800000, S_TWO = 32'h40000000;
    localparam logic [31:0] S_MONE = 32'hBF800000, S_MTWO = 32'hC0000000;
    localparam logic [31:0] S_PZ = 32'h00000000, S_NZ = 32'h80000000;
    localparam logic [31:0] S_PINF = 32'h7F800000, S_NINF = 32'hFF800000;
    localparam logic [31:0] S_QNAN = 32'h7FC00000, S_SNAN = 32'h7F800001;
    localparam logic [63:0] D_ONE = 64'h3FF0000000000000, D_TWO = 64'h4000000000000000;
    localparam logic [63:0] D_MTWO = 64'hC000000000000000, D_NZ = 64'h8000000000000000;
    localparam logic [63:0] D_QNAN = 64'h7FF8000000000000, D_SNAN = 64'h7FF0000000000001;

    task automatic check(input logic [1:0] act, input logic [1:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // one compare: drive at a falling edge, sample at the next falling edge
    task automatic run_cmp(input logic [63:0] a, input logic [63:0] b, input logic dbl,
                           input logic [1:0] exp, input string tag);
        @(negedge clk);
        op_a_i = a; op_b_i = b; dbl_i = dbl; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check({1'b0, done_o}, 2'd1, {tag, " done (R2)"});
        check(code_o, exp, tag);
    endtask

    task automatic t_reset();
        check({1'b0, done_o}, 2'd0, "R1 done in reset");
        check(code_o, 2'd0, "R1 code in reset");
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_order();
        run_cmp({32'h0, S_ONE}, {32'h0, S_TWO}, 1'b0, 2'd1, "R4 sp 1<2");
        run_cmp({32'h0, S_TWO}, {32'h0, S_ONE}, 1'b0, 2'd0, "R4 sp 2>1");
        run_cmp({32'h0, S_MTWO}, {32'h0, S_MONE}, 1'b0, 2'd1, "R4 sp -2<-1");
        run_cmp({32'h0, S_MONE}, {32'h0, S_MTWO}, 1'b0, 2'd0, "R4 sp -1>-2");
        run_cmp(D_MTWO, D_ONE, 1'b1, 2'd1, "R4 dp -2<1");
        run_cmp(D_ONE, D_MTWO, 1'b1, 2'd0, "R4 dp 1>-2");
        run_cmp({32'h0, S_ONE}, {32'h0, S_ONE}, 1'b0, 2'd0, "R5 sp equal");
        run_cmp(D_TWO, D_TWO, 1'b1, 2'd0, "R5 dp equal");
    endtask

    task automatic t_zeros();
        run_cmp({32'h0, S_NZ}, {32'h0, S_PZ}, 1'b0, 2'd1, "R6 sp -0 vs +0");
        run_cmp({32'h0, S_PZ}, {32'h0, S_NZ}, 1'b0, 2'd0, "R6 sp +0 vs -0");
        run_cmp({32'h0, S_NZ}, {32'h0, S_NZ}, 1'b0, 2'd0, "R6 sp -0 vs -0");
        run_cmp(D_NZ, 64'h0, 1'b1, 2'd1, "R6 dp -0 vs +0");
        run_cmp(64'h0, 64'h0, 1'b1, 2'd0, "R6 dp +0 vs +0");
    endtask

    task automatic t_nan();
        run_cmp({32'h0, S_ONE}, {32'h0, S_QNAN}, 1'b0, 2'd3, "R7 sp b qnan");
        run_cmp({32'h0, S_ONE}, {32'h0, S_SNAN}, 1'b0, 2'd3, "R7 sp b snan");
        run_cmp(D_SNAN, D_QNAN, 1'b1, 2'd3, "R7 dp both nan");
        run_cmp({32'h0, S_SNAN}, {32'h0, S_ONE}, 1'b0, 2'd2, "R8 sp a snan");
        run_cmp(D_QNAN, D_NZ, 1'b1, 2'd2, "R8 dp a qnan");
    endtask

    task automatic t_inf();
        run_cmp({32'h0, S_TWO}, {32'h0, S_PINF}, 1'b0, 2'd1, "R9 sp 2<+inf");
        run_cmp({32'h0, S_PINF}, {32'h0, S_TWO}, 1'b0, 2'd0, "R9 sp +inf>2");
        run_cmp({32'h0, S_NINF}, {32'h0, S_MTWO}, 1'b0, 2'd1, "R9 sp -inf<-2");
    endtask

    task automatic t_precision();
        // upper halves would read as double NaNs; single mode must ignore them
        run_cmp({32'h7FF80000, S_ONE}, {32'h7FF00000, S_TWO}, 1'b0, 2'd1, "R10 sp ignores upper");
        // low halves are zero; double mode must use the full word
        run_cmp(D_ONE, D_TWO, 1'b1, 2'd1, "R10 dp full width");
        run_cmp(D_TWO, D_ONE, 1'b1, 2'd0, "R10 dp full width rev");
    endtask

    task automatic t_hold();
        run_cmp({32'h0, S_SNAN}, {32'h0, S_ONE}, 1'b0, 2'd2, "R3 setup");
        op_a_i = D_ONE; op_b_i = D_QNAN; dbl_i = 1'b1;
        @(negedge clk);
        check({1'b0, done_o}, 2'd0, "R2 done low when idle");
        check(code_o, 2'd2, "R3 code held");
        op_a_i = 64'h0; op_b_i = 64'h0;
        @(negedge clk);
        check(code_o, 2'd2, "R3 code held later");
    endtask

    task automatic t_back_to_back();
        @(negedge clk);
        op_a_i = {32'h0, S_ONE}; op_b_i = {32'h0, S_QNAN}; dbl_i = 1'b0; start_i = 1'b1;
        @(negedge clk);
        check({1'b0, done_o}, 2'd1, "R2 b2b first done");
        check(code_o, 2'd3, "R7 b2b first");
        op_a_i = {32'h0, S_NZ}; op_b_i = {32'h0, S_PZ};
        @(negedge clk);
        start_i = 1'b0;
        check({1'b0, done_o}, 2'd1, "R2 b2b second done");
        check(code_o, 2'd1, "R6 b2b second");
        @(negedge clk);
        check({1'b0, done_o}, 2'd0, "R2 b2b done drops");
        check(code_o, 2'd1, "R3 b2b held");
    endtask

    initial begin
        #1;
        t_reset();
        t_order();
        t_zeros();
        t_nan();
        t_inf();
        t_precision();
        t_hold();
        t_back_to_back();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule